// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

The block holds three independent 16-bit down-counters that software programs over a small 8-bit register bus. Each counter advances only on cycles where its own count-enable tick is high. Each counter has a GATE input and a timer output. Software first writes a control word that picks a counter and sets its byte format, its operating mode and its number system. It then writes the initial count to that counter's own address.

Six output behaviours share one counter datapath:
- an event counter,
- a gate-retriggered one-shot,
- a rate generator,
- a square-wave generator that handles odd counts,
- a strobe started by software,
- a strobe started by the gate.

Any counter can count in binary or in four-digit BCD. Software can read the live count back through the same byte format that was used to load it.

All logic runs on one system clock. The tick inputs are clock enables, so a tick that lasts one cycle equals one count clock. GATE is sampled only on tick cycles. A gate trigger is a rising edge of GATE seen between two such samples.

Top module: `tri_interval_timer`

## Requirements
- R1: A bus write (sel and wr high) to address 3 is a control word. Bits [7:6] select the counter (0..2). Bits [5:4] set the byte format: 01 low byte only, 10 high byte only, 11 low byte then high byte. Bits [3:1] set the mode, where 6 and 7 mean 2 and 3. Bit 0 selects BCD. A word with select 3 or format 00 changes nothing. Writes to addresses 0..2 load count bytes. Bus reads return the selected counter's count byte without delay.
- R2: After reset every counter is in mode 0 with format 01, count 0 and output low. A control word drives the output low in mode 0 and high in every other mode.
- R3: Mode 0 counts events. After the count N is written, the output stays low for N+1 ticks, counting the tick that loads the count. It then rises and stays high until the counter is reprogrammed.
- R4: Mode 1 is a one-shot. A gate rising edge after a count has been written drives the output low for N ticks. A new edge during the pulse reloads N and lengthens the pulse.
- R5: Mode 2 is a rate generator. The output is high for N-1 ticks and low for 1 tick, and this repeats.
- R6: Mode 3 gives a square wave with period N. The output is high for ceil(N/2) ticks and low for floor(N/2) ticks.
- R7: Mode 4 is a strobe started by software. After the count is written, the output is high for N ticks, then low for one tick, then high again.
- R8: Mode 5 behaves like mode 4, but a gate rising edge starts it. A later edge restarts it. Without an edge the output stays high.
- R9: While GATE is low, modes 0, 2, 3 and 4 stop decrementing and their outputs hold.
- R10: BCD counting decrements four decimal digits with a borrow between digits. In format 11, the reads alternate low byte then high byte.
- R11: A count of 0 means 65536 in binary and 10000 in BCD. The first decrement after it reads FFFF or 9999.
- R12: A count written while mode 2 or 3 is running takes effect at the next period boundary.
- R13: Outputs and counts change only on tick cycles or on bus writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register bus select |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Counter 0..2 or control register (3) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data: a count byte of the addressed counter |
| cnt_tick | input | 3 | Per-counter count clock enable |
| gate_in | input | 3 | Per-counter GATE |
| tmr_out | output | 3 | Per-counter timer output |

## Verification
The assertions check four behaviours on every cycle:
- the output holds still when there is no tick and no write;
- the output stays high in mode 0 once it has risen;
- the counter holds still while the gate is low in the gated modes;
- the low pulse lasts a single tick in mode 2, and a mode 1 trigger lowers the output.

They also check that the bus decoder issues at most one write strobe per cycle.

The following behaviours have exact lengths or values that only the bench scenarios can show:
- the waveform lengths of each mode, including odd square-wave halves, retrigger extension and late reloads;
- BCD borrowing;
- the meaning of a zero count;
- the byte order of readback.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int DW     = 8;
  localparam int CNT_W  = 16;
  localparam int DIGITS = CNT_W / 4;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [CNT_W:0]   mag_t;

  typedef enum logic [1:0] {
    FMT_NONE = 2'b00,
    FMT_LO   = 2'b01,
    FMT_HI   = 2'b10,
    FMT_BOTH = 2'b11
  } fmt_e;

  // Fold the mode aliases 6 and 7 onto 2 and 3.
  function automatic logic [2:0] mode_of(input logic [2:0] m);
    return m[1] ? {1'b0, m[1:0]} : m;
  endfunction

  // Decrement by one, in binary or digit-wise BCD with borrow.
  function automatic cnt_t cnt_dec(input cnt_t v, input logic bcd);
    cnt_t r;
    logic borrow;
    r = v;
    borrow = 1'b1;
    if (!bcd) begin
      r = v - 1'b1;
    end else begin
      for (int d = 0; d < DIGITS; d++) begin
        if (borrow) begin
          if (v[d*4 +: 4] == 4'd0) r[d*4 +: 4] = 4'd9;
          else begin
            r[d*4 +: 4] = v[d*4 +: 4] - 4'd1;
            borrow = 1'b0;
          end
        end
      end
    end
    return r;
  endfunction

  // Count value as a plain magnitude; zero stands for the full range.
  function automatic mag_t cnt_mag(input cnt_t v, input logic bcd);
    int acc;
    int w;
    acc = 0;
    w = 1;
    if (bcd) begin
      for (int d = 0; d < DIGITS; d++) begin
        acc += int'(v[d*4 +: 4]) * w;
        w = w * 10;
      end
      if (v == '0) acc = w;
    end else begin
      acc = int'(v);
      if (v == '0) acc = 1 << CNT_W;
    end
    return mag_t'(acc);
  endfunction

  // Square wave: high while the remaining count exceeds half the period.
  function automatic logic sq_high(input mag_t cur, input mag_t per);
    return cur > (per >> 1);
  endfunction
endpackage

// File: rtl/itmr_bus_dec.sv
module itmr_bus_dec
  import itmr_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              rd,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [DW-1:0]     wdata,
  output logic [NUM_CH-1:0] ctrl_we,
  output logic [NUM_CH-1:0] data_we,
  output logic [NUM_CH-1:0] data_re
);
  localparam logic [1:0] CTRL_ADDR = 2'd3;

  logic wr_stb, rd_stb, ctrl_hit;
  assign wr_stb   = sel & wr;
  assign rd_stb   = sel & rd & ~wr;
  assign ctrl_hit = wr_stb && (addr == CTRL_ADDR) &&
                    (wdata[7:6] != 2'd3) && (wdata[5:4] != 2'd0);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign ctrl_we[i] = ctrl_hit && (wdata[7:6] == 2'(i));
    assign data_we[i] = wr_stb && (addr == 2'(i));
    assign data_re[i] = rd_stb && (addr == 2'(i));
  end

  // R1
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl_we, data_we}));
endmodule

// File: rtl/itmr_channel.sv
module itmr_channel
  import itmr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          gate,
  input  logic          ctrl_we,
  input  logic          data_we,
  input  logic          data_re,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          out
);
  localparam int PAD = CNT_W - DW;

  logic [2:0] mode_q;
  fmt_e       fmt_q;
  logic       bcd_q, wptr_q, rptr_q, pend_q, armed_q, run_q, out_q, gate_q;
  cnt_t       cr_q, ce_q, per_q, ce_dec;

  // Named internal events
  logic wr_any, rise_ev, trig_ev, load_ev, cnt_en, run_tick, term, wr_done;
  logic gated_mode, trig_mode;

  assign wr_any     = ctrl_we | data_we;
  assign rise_ev    = tick & gate & ~gate_q;
  assign trig_mode  = (mode_q == 3'd1) || (mode_q == 3'd5);
  assign gated_mode = !trig_mode;
  assign trig_ev    = rise_ev & armed_q & trig_mode & ~wr_any;
  assign load_ev    = tick & pend_q & gated_mode & ~wr_any;
  assign cnt_en     = trig_mode | gate;
  assign run_tick   = tick & run_q & cnt_en & ~wr_any & ~trig_ev;
  assign term       = (ce_q == cnt_t'(1));
  assign wr_done    = data_we && ((fmt_q != FMT_BOTH) || wptr_q);
  assign ce_dec     = cnt_dec(ce_q, bcd_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 3'd0;  fmt_q <= FMT_LO;  bcd_q <= 1'b0;
      cr_q <= '0;  ce_q <= '0;  per_q <= '0;
      wptr_q <= 1'b0;  rptr_q <= 1'b0;
      pend_q <= 1'b0;  armed_q <= 1'b0;  run_q <= 1'b0;
      out_q <= 1'b0;  gate_q <= 1'b1;
    end else begin
      if (tick) gate_q <= gate;
      if (data_re && fmt_q == FMT_BOTH) rptr_q <= ~rptr_q;

      if (ctrl_we) begin
        mode_q  <= mode_of(wdata[3:1]);
        fmt_q   <= fmt_e'(wdata[5:4]);
        bcd_q   <= wdata[0];
        out_q   <= (mode_of(wdata[3:1]) != 3'd0);
        pend_q  <= 1'b0;  armed_q <= 1'b0;  run_q <= 1'b0;
        wptr_q  <= 1'b0;  rptr_q  <= 1'b0;
      end else if (data_we) begin
        unique case (fmt_q)
          FMT_LO:   cr_q <= {{PAD{1'b0}}, wdata};
          FMT_HI:   cr_q <= {wdata, {PAD{1'b0}}};
          FMT_BOTH: begin
            if (!wptr_q) cr_q[DW-1:0] <= wdata;
            else         cr_q[CNT_W-1 -: DW] <= wdata;
            wptr_q <= ~wptr_q;
          end
          default: ;
        endcase
        if (wr_done) begin
          unique case (mode_q)
            3'd0:      begin pend_q <= 1'b1; run_q <= 1'b0; out_q <= 1'b0; end
            3'd1, 3'd5: armed_q <= 1'b1;
            3'd2, 3'd3: if (!run_q) pend_q <= 1'b1;
            3'd4:      begin pend_q <= 1'b1; run_q <= 1'b0; out_q <= 1'b1; end
            default: ;
          endcase
        end
      end else if (trig_ev) begin
        ce_q  <= cr_q;
        run_q <= 1'b1;
        out_q <= (mode_q != 3'd1);
      end else if (load_ev) begin
        ce_q   <= cr_q;
        per_q  <= cr_q;
        pend_q <= 1'b0;
        run_q  <= 1'b1;
        out_q  <= (mode_q != 3'd0);
      end else if (run_tick) begin
        unique case (mode_q)
          3'd0, 3'd1: begin
            if (term) begin out_q <= 1'b1; run_q <= 1'b0; end
            else ce_q <= ce_dec;
          end
          3'd2: begin
            if (term) begin ce_q <= cr_q; out_q <= 1'b1; end
            else begin
              ce_q <= ce_dec;
              if (ce_q == cnt_t'(2)) out_q <= 1'b0;
            end
          end
          3'd3: begin
            if (term) begin ce_q <= cr_q; per_q <= cr_q; out_q <= 1'b1; end
            else begin
              ce_q  <= ce_dec;
              out_q <= sq_high(cnt_mag(ce_dec, bcd_q), cnt_mag(per_q, bcd_q));
            end
          end
          default: begin
            if (!out_q)    begin out_q <= 1'b1; run_q <= 1'b0; end
            else if (term) out_q <= 1'b0;
            else           ce_q <= ce_dec;
          end
        endcase
      end
    end
  end

  always_comb begin
    unique case (fmt_q)
      FMT_HI:   rdata = ce_q[CNT_W-1 -: DW];
      FMT_BOTH: rdata = rptr_q ? ce_q[CNT_W-1 -: DW] : ce_q[DW-1:0];
      default:  rdata = ce_q[DW-1:0];
    endcase
  end

  assign out = out_q;

  // R13
  out_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ctrl_we && !data_we) |=> $stable(out));

  // R3
  evt_stays_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd0 && out && !ctrl_we && !data_we) |=> out);

  // R9
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !gate && run_q && gated_mode && !ctrl_we && !data_we) |=> $stable(ce_q));

  // R5
  rate_low_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd2 && run_q && !out && tick && gate && !ctrl_we && !data_we) |=> out);

  // R4
  trig_lowers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_ev && mode_q == 3'd1) |=> !out);
endmodule

// File: rtl/tri_interval_timer.sv
module tri_interval_timer
  import itmr_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NUM_CH-1:0] cnt_tick,
  input  logic [NUM_CH-1:0] gate_in,
  output logic [NUM_CH-1:0] tmr_out
);
  logic [NUM_CH-1:0] ctrl_we, data_we, data_re;
  logic [DW-1:0]     ch_rd [NUM_CH];

  itmr_bus_dec #(.NUM_CH(NUM_CH)) u_dec (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .rd(bus_rd), .wr(bus_wr),
    .addr(bus_addr), .wdata(bus_wdata),
    .ctrl_we(ctrl_we), .data_we(data_we), .data_re(data_re)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    itmr_channel u_ch (
      .clk(clk), .rst_n(rst_n), .tick(cnt_tick[i]), .gate(gate_in[i]),
      .ctrl_we(ctrl_we[i]), .data_we(data_we[i]), .data_re(data_re[i]),
      .wdata(bus_wdata), .rdata(ch_rd[i]), .out(tmr_out[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (bus_sel && bus_rd && bus_addr == 2'(i)) bus_rdata = ch_rd[i];
  end
endmodule

// File: tb/tb_tri_interval_timer.sv
`timescale 1ns/1ps
module tb_tri_interval_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [2:0] cnt_tick = '0;
  logic [2:0] gate_in = 3'b111;
  logic [2:0] tmr_out;

  always #2.5 clk = ~clk;

  tri_interval_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cnt_tick(cnt_tick), .gate_in(gate_in),
    .tmr_out(tmr_out)
  );

  typedef struct {
    int    kind;   // 0: timer output, 1: last read byte
    int    ch;
    int    exp;
    string tag;
  } item_t;

  item_t      exp_q[$];
  int         checks = 0;
  int         errors = 0;
  logic [7:0] rd_last = '0;
  event       chk_ev;

  // Monitor: pops expected items and compares with what the design shows.
  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        item_t it;
        int    act;
        it  = exp_q.pop_front();
        act = (it.kind == 0) ? int'(tmr_out[it.ch]) : int'(rd_last);
        checks++;
        if (act != it.exp) begin
          errors++;
          $display("FAIL %s ch%0d actual %0h expected %0h", it.tag, it.ch, act, it.exp);
        end
      end
    end
  end

  task automatic push(int kind, int ch, int v, string tag);
    item_t it;
    it.kind = kind; it.ch = ch; it.exp = v; it.tag = tag;
    exp_q.push_back(it);
    ->chk_ev;
  endtask

  task automatic expect_out(int ch, int v, string tag);
    push(0, ch, v, tag);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, int exp_v, string tag);
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
    #1 rd_last = bus_rdata;
    push(1, int'(a), exp_v, tag);
    @(negedge clk);
    bus_sel = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic step(int ch);
    cnt_tick[ch] = 1'b1;
    @(negedge clk);
    cnt_tick[ch] = 1'b0;
  endtask

  bit done = 0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R13 watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    for (int c = 0; c < 3; c++) expect_out(c, 0, "R2 reset out");
    rd(2'd0, 8'h00, "R2 reset count");

    // R3 mode 0, N=5: low through 6 ticks including load
    wr(2'd3, 8'h10);
    expect_out(0, 0, "R2 mode0 ctrl low");
    wr(2'd0, 8'd5);
    for (int k = 1; k <= 8; k++) begin
      step(0);
      expect_out(0, (k >= 6) ? 1 : 0, "R3 event count");
    end

    // R9 / R3 gate pause in mode 0
    wr(2'd3, 8'h10);
    wr(2'd0, 8'd3);
    step(0);
    expect_out(0, 0, "R3 load");
    gate_in[0] = 1'b0;
    for (int k = 0; k < 4; k++) begin
      step(0);
      expect_out(0, 0, "R9 mode0 paused");
    end
    gate_in[0] = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      step(0);
      expect_out(0, (k >= 3) ? 1 : 0, "R3 resume after gate");
    end

    // R4 mode 1 one-shot with retrigger, ch1, N=3
    wr(2'd3, 8'h52);
    expect_out(1, 1, "R2 mode1 ctrl high");
    wr(2'd1, 8'd3);
    gate_in[1] = 1'b0;
    step(1);
    expect_out(1, 1, "R4 no trigger yet");
    gate_in[1] = 1'b1; step(1); expect_out(1, 0, "R4 trigger t0");
    gate_in[1] = 1'b0; step(1); expect_out(1, 0, "R4 t1");
    gate_in[1] = 1'b1; step(1); expect_out(1, 0, "R4 retrigger t2");
    step(1); expect_out(1, 0, "R4 t3 extended");
    step(1); expect_out(1, 0, "R4 t4 extended");
    step(1); expect_out(1, 1, "R4 t5 end");
    step(1); expect_out(1, 1, "R4 stays high");

    // R1 ignored control words
    wr(2'd3, 8'hC0);
    wr(2'd3, 8'h40);
    expect_out(1, 1, "R1 ignored words keep ch1");
    expect_out(0, 1, "R1 ignored words keep ch0");

    // R5 mode 2, ch2, N=4 written low then high byte; R12 late reload
    wr(2'd3, 8'hB4);
    wr(2'd2, 8'd4);
    wr(2'd2, 8'd0);
    for (int k = 0; k <= 12; k++) begin
      step(2);
      expect_out(2, (k % 4 == 3) ? 0 : 1, "R5 rate gen");
    end
    wr(2'd2, 8'd6);
    wr(2'd2, 8'd0);
    for (int k = 13; k <= 22; k++) begin
      step(2);
      expect_out(2, (k == 15 || k == 21) ? 0 : 1, "R12 reload at period end");
    end
    gate_in[2] = 1'b0;
    for (int k = 0; k < 3; k++) begin
      step(2);
      expect_out(2, 1, "R9 mode2 paused");
    end
    rd(2'd2, 8'd6, "R9 count held low byte");
    rd(2'd2, 8'd0, "R10 pointer high byte");
    repeat (5) @(negedge clk);
    rd(2'd2, 8'd6, "R13 no tick no change");
    rd(2'd2, 8'd0, "R13 no tick high byte");
    gate_in[2] = 1'b1;

    // R6 mode 3 odd and even
    wr(2'd3, 8'h16);
    wr(2'd0, 8'd5);
    for (int k = 0; k < 15; k++) begin
      step(0);
      expect_out(0, (k % 5 < 3) ? 1 : 0, "R6 square odd");
    end
    wr(2'd3, 8'h16);
    wr(2'd0, 8'd4);
    for (int k = 0; k < 12; k++) begin
      step(0);
      expect_out(0, (k % 4 < 2) ? 1 : 0, "R6 square even");
    end

    // R7 mode 4, ch1, N=3
    wr(2'd3, 8'h58);
    expect_out(1, 1, "R2 mode4 ctrl high");
    wr(2'd1, 8'd3);
    for (int k = 0; k < 7; k++) begin
      step(1);
      expect_out(1, (k == 3) ? 0 : 1, "R7 sw strobe");
    end

    // R8 mode 5, ch2, N=2 with retrigger
    wr(2'd3, 8'h9A);
    wr(2'd2, 8'd2);
    gate_in[2] = 1'b0;
    for (int k = 0; k < 3; k++) begin
      step(2);
      expect_out(2, 1, "R8 idle without trigger");
    end
    gate_in[2] = 1'b1; step(2); expect_out(2, 1, "R8 trigger t0");
    gate_in[2] = 1'b0; step(2); expect_out(2, 1, "R8 t1");
    gate_in[2] = 1'b1; step(2); expect_out(2, 1, "R8 retrigger t2");
    step(2); expect_out(2, 1, "R8 t3");
    step(2); expect_out(2, 0, "R8 strobe t4");
    step(2); expect_out(2, 1, "R8 t5");

    // R10 BCD borrow
    wr(2'd3, 8'h11);
    wr(2'd0, 8'h10);
    step(0);
    step(0);
    rd(2'd0, 8'h09, "R10 bcd 10 minus 1");

    // R11 BCD zero = 10000
    wr(2'd3, 8'h31);
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h00);
    step(0);
    step(0);
    rd(2'd0, 8'h99, "R11 bcd wrap low");
    rd(2'd0, 8'h99, "R11 bcd wrap high");
    for (int k = 0; k < 9998; k++) step(0);
    expect_out(0, 0, "R11 bcd zero still low");
    step(0);
    expect_out(0, 1, "R11 bcd zero ends at 10001");

    // R11 binary zero
    wr(2'd3, 8'h30);
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h00);
    step(0);
    step(0);
    rd(2'd0, 8'hFF, "R11 bin wrap low");
    rd(2'd0, 8'hFF, "R11 bin wrap high");

    // R1 high-byte-only format
    wr(2'd3, 8'h20);
    wr(2'd0, 8'h01);
    step(0);
    rd(2'd0, 8'h01, "R1 msb only load");
    step(0);
    rd(2'd0, 8'h00, "R1 msb only after dec");

    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule